// File: doc/BRIEF.md
# Claim-Wire Bus Ownership Arbiter

This block settles which of several masters may drive a shared I2C bus. It does not use I2C's own multi-master arbitration: every master owns one dedicated active-low claim wire that the others can read. All claim wires are pulled up, so a wire that is released or not driven reads as "not claiming". The local I2C controller raises a request, and the block drives its own claim wire low. It then waits a settling interval and checks the other masters' claim wires, each of which first passes through a two-flop synchronizer.

If nobody else is claiming, the block grants the bus and keeps its claim low until the controller pulses release. If another master is claiming, the block keeps its claim and waits up to one retry interval for all rivals to let go. It grants as soon as they do. Otherwise it drops its claim, waits another retry interval, and starts again. An overall budget, counted from the accepted request, ends the attempt with a one-cycle fail pulse. Dropping the request while the attempt is still open abandons it.

All intervals are parameters in clock cycles. By default they are derived from a clock frequency in MHz and microsecond settings: 10 us settle, 3000 us retry and 50000 us budget.

Top module: `claim_arbiter`

## Requirements
- R1: In reset and after it, `claim_n_o` is 1 (released), and `grant_o` and `fail_o` are 0.
- R2: When `req_i` is 1 while the block is idle, `claim_n_o` goes to 0 on the next clock edge.
- R3: If no rival claim input (active low, so a 0 means claiming) is seen at the end of the settle interval, `grant_o` rises after exactly SETTLE_CYC cycles with the claim driven low. With an idle start, this is SETTLE_CYC+1 edges after `req_i` is first sampled.
- R4: While `grant_o` is 1, `claim_n_o` is 0, and it stays so until release.
- R5: If a rival is claiming at the end of the settle interval, the block keeps `claim_n_o` at 0 for up to RETRY_CYC cycles. It grants on the first cycle in which no rival is seen.
- R6: If rivals are still claiming after that wait, `claim_n_o` goes to 1 for exactly RETRY_CYC cycles, and then a new settle phase starts with the claim driven low again.
- R7: On the BUDGET_CYC-th cycle of an attempt without a grant, `fail_o` is 1 for exactly one cycle with `claim_n_o` at 1. The block then returns to idle.
- R8: A `release_i` pulse while granted clears `grant_o` and sets `claim_n_o` to 1 on the next edge.
- R9: If `req_i` is 0 while settling, waiting or backing off, the next edge releases the claim and returns to idle with no grant and no fail.
- R10: A change on a rival claim input affects the decision three edges after it is driven, because of the two-flop synchronizer and the state register.
- R11: Any of the N_RIVALS claim inputs at 0 counts as a rival claim. Input bit i belongs to rival i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Local controller wants the bus (level) |
| release_i | input | 1 | Local controller is done with the bus (pulse) |
| grant_o | output | 1 | Bus owned by the local controller |
| fail_o | output | 1 | One-cycle pulse: attempt budget exhausted |
| claim_n_o | output | 1 | Own claim wire, active low |
| rival_claim_n_i | input | N_RIVALS | Other masters' claim wires, active low, asynchronous |

## Verification
A wrong state or timer value shows first on `claim_n_o`. The claim goes high a cycle early or late at a back-off boundary, or a grant appears or is missing at the settle edge. The per-cycle reference comparison catches this on the same cycle the divergence reaches a port. A corrupted budget count only shows at the fail pulse, up to BUDGET_CYC cycles later. For that reason the bench runs a full-contention attempt to its end. A synchronizer fault shifts the grant after a rival's release by one cycle, and the bench measures that delay.

// File: rtl/claim_arb_pkg.sv
package claim_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_HOLD,
        ST_BACKOFF,
        ST_OWNED,
        ST_GIVEUP
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
    } arb_regs_t;

    function automatic int unsigned us_to_cycles(int unsigned mhz, int unsigned us);
        return mhz * us;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rival_sync.sv
module rival_sync #(
    parameter int unsigned LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw_n_i,
    output logic [LANES-1:0] sync_n_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic meta_d, meta_q;
        logic stab_d, stab_q;

        always_comb begin
            meta_d = raw_n_i[g];
            stab_d = meta_q;
        end

        // Reset to 1: a released (pulled-up) wire.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= meta_d;
                stab_q <= stab_d;
            end
        end

        assign sync_n_o[g] = stab_q;
    end

endmodule

// File: rtl/cycle_down.sv
module cycle_down #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         run_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R7: a drained counter stays drained until reloaded, so expiry is sticky
    p_timer_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/claim_arbiter.sv
module claim_arbiter
    import claim_arb_pkg::*;
#(
    parameter int unsigned N_RIVALS   = 1,
    parameter int unsigned CLK_MHZ    = 200,
    parameter int unsigned SETTLE_US  = 10,
    parameter int unsigned RETRY_US   = 3000,
    parameter int unsigned BUDGET_US  = 50000,
    parameter int unsigned SETTLE_CYC = us_to_cycles(CLK_MHZ, SETTLE_US),
    parameter int unsigned RETRY_CYC  = us_to_cycles(CLK_MHZ, RETRY_US),
    parameter int unsigned BUDGET_CYC = us_to_cycles(CLK_MHZ, BUDGET_US)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                release_i,
    output logic                grant_o,
    output logic                fail_o,
    output logic                claim_n_o,
    input  logic [N_RIVALS-1:0] rival_claim_n_i
);

    localparam int unsigned PH_MAX = max_u(SETTLE_CYC, RETRY_CYC);
    localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
    localparam int unsigned BUD_W  = $clog2(BUDGET_CYC + 1);
    localparam logic [PH_W-1:0]  SETTLE_LD = PH_W'(SETTLE_CYC - 1);
    localparam logic [PH_W-1:0]  RETRY_LD  = PH_W'(RETRY_CYC - 1);
    localparam logic [BUD_W-1:0] BUDGET_LD = BUD_W'(BUDGET_CYC - 1);

    arb_regs_t         cur, nxt;
    logic [N_RIVALS-1:0] rivals_n;
    logic              rival_busy;
    logic              ph_load, ph_zero;
    logic [PH_W-1:0]   ph_val;
    logic              bud_load, bud_zero;
    logic              attempt_open;

    rival_sync #(.LANES(N_RIVALS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_n_i  (rival_claim_n_i),
        .sync_n_o (rivals_n)
    );

    // Any rival wire pulled low is a competing claim.
    assign rival_busy = ~&rivals_n;

    assign attempt_open = (cur.st == ST_SETTLE) || (cur.st == ST_HOLD) ||
                          (cur.st == ST_BACKOFF);

    cycle_down #(.W(PH_W)) phase_tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ph_load),
        .load_val_i (ph_val),
        .run_i      (attempt_open),
        .zero_o     (ph_zero)
    );

    cycle_down #(.W(BUD_W)) budget_tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (bud_load),
        .load_val_i (BUDGET_LD),
        .run_i      (attempt_open),
        .zero_o     (bud_zero)
    );

    always_comb begin
        nxt      = cur;
        ph_load  = 1'b0;
        ph_val   = '0;
        bud_load = 1'b0;
        unique case (cur.st)
            ST_IDLE: begin
                if (req_i) begin
                    nxt.st   = ST_SETTLE;
                    ph_load  = 1'b1;
                    ph_val   = SETTLE_LD;
                    bud_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!req_i) begin
                    nxt.st = ST_IDLE;
                end else if (ph_zero && !rival_busy) begin
                    nxt.st = ST_OWNED;
                end else if (bud_zero) begin
                    nxt.st = ST_GIVEUP;
                end else if (ph_zero) begin
                    nxt.st  = ST_HOLD;
                    ph_load = 1'b1;
                    ph_val  = RETRY_LD;
                end
            end
            ST_HOLD: begin
                if (!req_i) begin
                    nxt.st = ST_IDLE;
                end else if (!rival_busy) begin
                    nxt.st = ST_OWNED;
                end else if (bud_zero) begin
                    nxt.st = ST_GIVEUP;
                end else if (ph_zero) begin
                    nxt.st  = ST_BACKOFF;
                    ph_load = 1'b1;
                    ph_val  = RETRY_LD;
                end
            end
            ST_BACKOFF: begin
                if (!req_i) begin
                    nxt.st = ST_IDLE;
                end else if (bud_zero) begin
                    nxt.st = ST_GIVEUP;
                end else if (ph_zero) begin
                    nxt.st  = ST_SETTLE;
                    ph_load = 1'b1;
                    ph_val  = SETTLE_LD;
                end
            end
            ST_OWNED: begin
                if (release_i) begin
                    nxt.st = ST_IDLE;
                end
            end
            ST_GIVEUP: begin
                nxt.st = ST_IDLE;
            end
            default: begin
                nxt.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur.st <= ST_IDLE;
        end else begin
            cur <= nxt;
        end
    end

    assign claim_n_o = !((cur.st == ST_SETTLE) || (cur.st == ST_HOLD) ||
                         (cur.st == ST_OWNED));
    assign grant_o   = (cur.st == ST_OWNED);
    assign fail_o    = (cur.st == ST_GIVEUP);

    // R2
    p_claim_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.st == ST_IDLE && req_i) |=> !claim_n_o);
    // R3
    p_grant_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(!rival_busy));
    // R4
    p_grant_holds_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !claim_n_o);
    // R5
    p_hold_keeps_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.st == ST_HOLD && req_i && rival_busy && !ph_zero && !bud_zero)
        |=> !claim_n_o);
    // R6
    p_reclaim_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.st == ST_BACKOFF && nxt.st == ST_SETTLE) |-> ph_zero);
    // R7
    p_fail_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);
    p_fail_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (claim_n_o && !grant_o));
    // R8
    p_release_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && release_i) |=> (claim_n_o && !grant_o));
    // R9
    p_drop_abandons_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt_open && !req_i) |=> (claim_n_o && !grant_o && !fail_o));

endmodule

// File: tb/claim_arbiter_tb_top.sv
`timescale 1ns/1ps
module claim_arbiter_tb_top;

    localparam int N = 2;
    localparam int S = 4;
    localparam int R = 10;
    localparam int B = 60;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic         rel = 1'b0;
    logic [N-1:0] rivals_n = '1;
    logic         claim_n, grant, fail;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    claim_arbiter #(
        .N_RIVALS(N), .SETTLE_CYC(S), .RETRY_CYC(R), .BUDGET_CYC(B)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .release_i(rel),
        .grant_o(grant), .fail_o(fail), .claim_n_o(claim_n),
        .rival_claim_n_i(rivals_n)
    );

    // Reference model: 0 idle, 1 settle, 2 hold, 3 backoff, 4 owned, 5 failed
    int           m_st = 0;
    int           m_t = 0;
    int           m_b = 0;
    logic [N-1:0] m_hist[$];
    logic [N-1:0] m_seen;
    bit           m_others;
    bit           m_claim_n = 1'b1;
    bit           m_grant = 1'b0;
    bit           m_fail = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_t = 0; m_b = 0;
            m_hist.delete();
            m_hist.push_back({N{1'b1}});
            m_hist.push_back({N{1'b1}});
        end else begin
            m_seen = m_hist.pop_front();
            m_hist.push_back(rivals_n);
            m_others = (m_seen != {N{1'b1}});
            case (m_st)
                0: if (req) begin m_st = 1; m_t = 0; m_b = 0; end
                1, 2, 3: begin
                    m_t++; m_b++;
                    if (!req) m_st = 0;
                    else if (m_st == 1) begin
                        if (m_t == S && !m_others) m_st = 4;
                        else if (m_b == B) m_st = 5;
                        else if (m_t == S) begin m_st = 2; m_t = 0; end
                    end else if (m_st == 2) begin
                        if (!m_others) m_st = 4;
                        else if (m_b == B) m_st = 5;
                        else if (m_t == R) begin m_st = 3; m_t = 0; end
                    end else begin
                        if (m_b == B) m_st = 5;
                        else if (m_t == R) begin m_st = 1; m_t = 0; end
                    end
                end
                4: if (rel) m_st = 0;
                default: m_st = 0;
            endcase
        end
        m_claim_n = !(m_st == 1 || m_st == 2 || m_st == 4);
        m_grant   = (m_st == 4);
        m_fail    = (m_st == 5);
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Every-cycle comparison with the model, plus the watchdog.
    always @(negedge clk) begin
        cyc++;
        checks++;
        if (claim_n !== m_claim_n || grant !== m_grant || fail !== m_fail) begin
            errors++;
            $display("FAIL %s cycle %0d: claim_n/grant/fail = %b%b%b expected %b%b%b",
                     tag, cyc, claim_n, grant, fail, m_claim_n, m_grant, m_fail);
        end
        if (cyc > 200000) begin
            errors++;
            $display("FAIL watchdog: %0d cycles expected under 200000", cyc);
            finish_run();
        end
    end

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    int cnt;
    int high_cnt;
    int fail_at;

    initial begin
        // R1: reset state
        tag = "R1";
        step(3);
        check(claim_n == 1'b1, "R1", "claim_n in reset", int'(claim_n), 1);
        check(grant == 1'b0 && fail == 1'b0, "R1", "grant|fail in reset",
              int'(grant | fail), 0);
        rst_n = 1'b1;
        step(2);
        check(claim_n == 1'b1, "R1", "claim_n after reset", int'(claim_n), 1);

        // R2, R3, R4, R8: free bus
        tag = "R3";
        req = 1'b1;
        step(1);
        check(claim_n == 1'b0, "R2", "claim one edge after request", int'(claim_n), 0);
        cnt = 1;
        while (!grant && cnt < 50) begin step(1); cnt++; end
        check(cnt == S + 1, "R3", "edges from request to grant", cnt, S + 1);
        tag = "R4";
        step(3);
        check(grant && !claim_n, "R4", "claim held while granted", int'(claim_n), 0);
        tag = "R8";
        rel = 1'b1; req = 1'b0;
        step(1);
        rel = 1'b0;
        check(!grant && claim_n, "R8", "claim released after release pulse",
              int'(claim_n), 1);
        step(5);

        // R5, R10: rival 0 claims, releases during hold
        tag = "R5";
        rivals_n[0] = 1'b0;
        step(3);
        req = 1'b1;
        step(S + 4);
        check(claim_n == 1'b0 && !grant, "R5", "claim kept while rival holds",
              int'(claim_n), 0);
        rivals_n[0] = 1'b1;
        cnt = 0;
        while (!grant && cnt < 50) begin step(1); cnt++; end
        check(cnt == 3, "R10", "edges from rival release to grant", cnt, 3);
        check(!claim_n, "R5", "granted with claim held", int'(claim_n), 0);
        tag = "R8";
        rel = 1'b1; req = 1'b0;
        step(1);
        rel = 1'b0;
        step(5);

        // R6, R7, R11: rival 1 holds throughout
        tag = "R7";
        rivals_n[1] = 1'b0;
        step(3);
        req = 1'b1;
        cnt = 0; high_cnt = 0; fail_at = -1;
        while (fail_at < 0 && cnt < 200) begin
            step(1); cnt++;
            if (fail) fail_at = cnt;
            else if (claim_n) high_cnt++;
        end
        check(fail_at == B + 1, "R7", "edges from request to fail", fail_at, B + 1);
        check(high_cnt == 2 * R, "R6", "released cycles before fail", high_cnt, 2 * R);
        check(claim_n == 1'b1, "R7", "claim released at fail", int'(claim_n), 1);
        req = 1'b0;
        step(1);
        check(!fail, "R7", "fail lasts one cycle", int'(fail), 0);
        check(grant == 1'b0, "R11", "no grant while rival 1 claims", int'(grant), 0);

        // R9: drop request while waiting
        tag = "R9";
        step(3);
        req = 1'b1;
        step(S + 3);
        req = 1'b0;
        step(1);
        check(claim_n && !grant && !fail, "R9", "abandon on dropped request",
              int'(claim_n), 1);
        step(10);
        check(claim_n && !grant, "R9", "stays idle after abandon", int'(grant), 0);
        rivals_n = '1;
        step(5);
        finish_run();
    end

endmodule